// File: doc/BRIEF.md
# Card-host transmit FIFO with start-threshold control

This block is the outgoing data buffer of a memory-card host controller. The system side pushes 32-bit words into a small FIFO. The card side drains words once the block write has been released. The block decides the release point. When a new command is accepted, it captures the fill policy and the block length, then compares the FIFO level with a threshold derived from them. When the level reaches that threshold, it raises a one-cycle start strobe.

The threshold follows the block length measured against the FIFO's byte capacity. A long block starts at half fill and a medium block at quarter fill. A short block waits until the whole block is buffered. An "eager" mode releases the transfer after the first word. Two sticky flags record a push into a full FIFO and a pop from an empty FIFO after release. A mode input selects what clears them: either the next accepted command or a status read.

Top module: `cardtx_fifo`

## Requirements
- R1: With `cfg_fill_any`=1, the threshold is one word. `xfer_go` is high for one cycle, starting on the cycle after the level first reaches the threshold.
- R2: With `cfg_fill_any`=0 and a block length of at least 48 bytes (three quarters of the 64-byte capacity), the threshold is 8 words.
- R3: With `cfg_fill_any`=0 and a block length from 32 to 47 bytes, the threshold is 4 words.
- R4: With `cfg_fill_any`=0 and a block length below 32 bytes, the threshold is the length in words rounded up, with a minimum of one word.
- R5: `xfer_go` fires at most once per accepted command. A new `cmd_start` re-arms it, and a FIFO already at threshold then fires two cycles after the `cmd_start` cycle.
- R6: The threshold uses the fill mode and length present at `cmd_start`. Later changes to those inputs have no effect on the armed block.
- R7: A push while the level is 16 is dropped. The level stays 16 and `flag_ovr` is set.
- R8: A pop before release is ignored and leaves the level unchanged. A pop after release with an empty FIFO sets `flag_unr`.
- R9: With `cfg_clr_on_read`=0, a set flag survives `stat_rd` and is cleared by the next `cmd_start`.
- R10: With `cfg_clr_on_read`=1, a set flag survives `cmd_start` and is cleared by `stat_rd`.
- R11: If an error event and a clearing action fall in the same cycle, the flag stays set.
- R12: Words leave in push order. `card_data` holds the popped word from the cycle after the pop.
- R13: After reset, the level and both flags are 0 and `xfer_go` is low. No strobe occurs until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | New write command accepted; captures the configuration and re-arms the strobe |
| cfg_fill_any | input | 1 | 1 = release after one word; 0 = length-based threshold |
| cfg_clr_on_read | input | 1 | 1 = status read clears flags; 0 = next command clears flags |
| cfg_blk_len | input | 12 | Block length in bytes |
| sys_push | input | 1 | Push request from the system side |
| sys_data | input | 32 | Word to push |
| card_pop | input | 1 | Pop request from the card side |
| stat_rd | input | 1 | Status read strobe |
| card_data | output | 32 | Last popped word |
| xfer_go | output | 1 | One-cycle start-transfer strobe |
| level | output | 5 | FIFO occupancy in words |
| flag_ovr | output | 1 | Sticky overflow flag |
| flag_unr | output | 1 | Sticky underflow flag |

## Verification
The threshold function is driven from a table of fill-mode and length pairs, with words pushed one at a time. The bench records the push after which the strobe appears and counts the pulses. The lengths sit on both sides of the 48-byte and 32-byte boundaries, which separates the half-fill and quarter-fill bands. In the short band, lengths of 0, 4, 5, 20 and 31 bytes separate the rounding-up rule from a rule that truncates or ignores the minimum. Directed sequences then change the configuration after capture, re-arm on a full FIFO, overfill and overdrain, and exercise both clearing modes, including a clear and an error in the same cycle.

// File: rtl/cardtx_pkg.sv
package cardtx_pkg;
  typedef enum logic [1:0] {
    THR_ONE_WORD,
    THR_HALF,
    THR_QUARTER,
    THR_WHOLE_BLOCK
  } thr_sel_e;
endpackage

// File: rtl/cardtx_thresh.sv
module cardtx_thresh #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             fill_any,
  input  logic [LEN_W-1:0] blk_len,
  output logic [CNT_W-1:0] thr_words
);
  import cardtx_pkg::*;

  localparam int BPW = DATA_W / 8;
  localparam int CAP = DEPTH * BPW;

  thr_sel_e    sel;
  logic [31:0] len32;
  logic [31:0] whole_words;

  assign len32       = 32'(blk_len);
  assign whole_words = (len32 + 32'(BPW - 1)) / 32'(BPW);

  always_comb begin
    if (fill_any)                         sel = THR_ONE_WORD;
    else if (len32 * 32'd4 >= 32'(3 * CAP)) sel = THR_HALF;
    else if (len32 * 32'd2 >= 32'(CAP))     sel = THR_QUARTER;
    else                                  sel = THR_WHOLE_BLOCK;
  end

  always_comb begin
    case (sel)
      THR_ONE_WORD: thr_words = CNT_W'(1);
      THR_HALF:     thr_words = CNT_W'(DEPTH / 2);
      THR_QUARTER:  thr_words = CNT_W'(DEPTH / 4);
      default:      thr_words = (whole_words == 32'd0) ? CNT_W'(1) : CNT_W'(whole_words);
    endcase
  end
endmodule

// File: rtl/cardtx_mem.sv
module cardtx_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  input  logic              pop_ok,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  level,
  output logic              push_drop,
  output logic              pop_under
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, empty, wr_en, rd_en;

  assign full      = (level == CNT_W'(DEPTH));
  assign empty     = (level == '0);
  assign wr_en     = push && !full;
  assign rd_en     = pop && pop_ok && !empty;
  assign push_drop = push && full;
  assign pop_under = pop && pop_ok && empty;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (wr_en) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == CNT_W'(DEPTH))); // R7
  AST_POP_GATED: assert property (@(posedge clk) disable iff (rst)
    (pop && !pop_ok && !push) |=> $stable(level)); // R8
endmodule

// File: rtl/cardtx_start.sv
module cardtx_start #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd,
  input  logic             fill_any,
  input  logic [LEN_W-1:0] blk_len,
  input  logic [CNT_W-1:0] level,
  output logic             go,
  output logic             started
);
  logic             armed, fill_l;
  logic [LEN_W-1:0] len_l;
  logic [CNT_W-1:0] thr;

  cardtx_thresh #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_thresh (
    .fill_any  (fill_l),
    .blk_len   (len_l),
    .thr_words (thr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      started <= 1'b0;
      go      <= 1'b0;
      fill_l  <= 1'b0;
      len_l   <= '0;
    end else begin
      go <= 1'b0;
      if (cmd) begin
        armed   <= 1'b1;
        started <= 1'b0;
        fill_l  <= fill_any;
        len_l   <= blk_len;
      end else if (armed && (level >= thr)) begin
        go      <= 1'b1;
        armed   <= 1'b0;
        started <= 1'b1;
      end
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    go |=> !go); // R5
  AST_GO_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
    go |-> (level != '0)); // R1
  AST_GO_RELEASES: assert property (@(posedge clk) disable iff (rst)
    go |-> started); // R8
endmodule

// File: rtl/cardtx_flag.sv
module cardtx_flag (
  input  logic clk,
  input  logic rst,
  input  logic evt,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (evt) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
    (evt && clr) |=> flag); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (flag && clr && !evt) |=> !flag); // R10
endmodule

// File: rtl/cardtx_fifo.sv
module cardtx_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LEN_W  = 12,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_start,
  input  logic              cfg_fill_any,
  input  logic              cfg_clr_on_read,
  input  logic [LEN_W-1:0]  cfg_blk_len,
  input  logic              sys_push,
  input  logic [DATA_W-1:0] sys_data,
  input  logic              card_pop,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] card_data,
  output logic              xfer_go,
  output logic [CNT_W-1:0]  level,
  output logic              flag_ovr,
  output logic              flag_unr
);
  localparam int NFLAG = 2;

  logic             started, push_drop, pop_under, flag_clr;
  logic [NFLAG-1:0] evts, flags;

  cardtx_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .push      (sys_push),
    .wdata     (sys_data),
    .pop       (card_pop),
    .pop_ok    (started),
    .rdata     (card_data),
    .level     (level),
    .push_drop (push_drop),
    .pop_under (pop_under)
  );

  cardtx_start #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_start (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd_start),
    .fill_any (cfg_fill_any),
    .blk_len  (cfg_blk_len),
    .level    (level),
    .go       (xfer_go),
    .started  (started)
  );

  assign flag_clr = cfg_clr_on_read ? stat_rd : cmd_start;
  assign evts     = {pop_under, push_drop};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    cardtx_flag u_flag (
      .clk  (clk),
      .rst  (rst),
      .evt  (evts[i]),
      .clr  (flag_clr),
      .flag (flags[i])
    );
  end

  assign flag_ovr = flags[0];
  assign flag_unr = flags[1];

  AST_OVR_ON_FULL_PUSH: assert property (@(posedge clk) disable iff (rst)
    (sys_push && (level == CNT_W'(DEPTH))) |=> flag_ovr); // R7
  AST_NO_GO_IDLE: assert property (@(posedge clk) disable iff (rst)
    (xfer_go && !$past(cmd_start)) |=> !xfer_go); // R5
endmodule

// File: tb/test_cardtx_fifo.sv
module test_cardtx_fifo;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int LEN_W  = 12;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NV     = 11;
  // {fill mode (4 bits), block length in bytes (12 bits), expected threshold in words (8 bits)}
  localparam logic [23:0] VEC [NV] = '{
    24'h1_040_01, 24'h0_040_08, 24'h0_030_08, 24'h0_02F_04, 24'h0_020_04, 24'h0_01F_08,
    24'h0_014_05, 24'h0_004_01, 24'h0_000_01, 24'h0_005_02, 24'h1_008_01
  };

  logic              clk = 1'b0;
  logic              rst, cmd_start, cfg_fill_any, cfg_clr_on_read, sys_push, card_pop, stat_rd;
  logic [LEN_W-1:0]  cfg_blk_len;
  logic [DATA_W-1:0] sys_data, card_data;
  logic              xfer_go, flag_ovr, flag_unr;
  logic [CNT_W-1:0]  level;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  cardtx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH), .LEN_W(LEN_W)) i_cardtx_fifo (
    .clk(clk), .rst(rst), .cmd_start(cmd_start), .cfg_fill_any(cfg_fill_any),
    .cfg_clr_on_read(cfg_clr_on_read), .cfg_blk_len(cfg_blk_len), .sys_push(sys_push),
    .sys_data(sys_data), .card_pop(card_pop), .stat_rd(stat_rd), .card_data(card_data),
    .xfer_go(xfer_go), .level(level), .flag_ovr(flag_ovr), .flag_unr(flag_unr)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; cmd_start = 0; sys_push = 0; card_pop = 0; stat_rd = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cmd(logic fill, logic [LEN_W-1:0] len);
    @(negedge clk);
    cmd_start = 1'b1; cfg_fill_any = fill; cfg_blk_len = len;
    @(negedge clk);
    cmd_start = 1'b0;
  endtask

  task automatic push(logic [DATA_W-1:0] d);
    @(negedge clk);
    sys_push = 1'b1; sys_data = d;
    @(negedge clk);
    sys_push = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    card_pop = 1'b1;
    @(negedge clk);
    card_pop = 1'b0;
  endtask

  task automatic rd_status();
    @(negedge clk);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_start = 0; cfg_fill_any = 0; cfg_clr_on_read = 0; cfg_blk_len = '0;
    sys_push = 0; sys_data = '0; card_pop = 0; stat_rd = 0;

    // Table walk: threshold selection, R1 to R4
    for (int v = 0; v < NV; v++) begin
      automatic logic       fill = VEC[v][20];
      automatic logic [LEN_W-1:0] len = VEC[v][19:8];
      automatic int         thr = int'(VEC[v][7:0]);
      automatic int         first = 0, pulses = 0;
      automatic string      tag = fill ? "R1" : (len >= 48) ? "R2" : (len >= 32) ? "R3" : "R4";
      do_reset();
      cmd(fill, len);
      for (int k = 1; k <= 10; k++) begin
        push(DATA_W'(k));
        @(negedge clk);
        if (xfer_go) begin
          pulses++;
          if (first == 0) first = k;
        end
      end
      chk(tag, $sformatf("go after push, len=%0d", len), first, thr);
      chk(tag, "go pulse count", pulses, 1);
    end

    // R13: reset state, no strobe before a command
    do_reset();
    chk("R13", "level after reset", level, 0);
    chk("R13", "ovr after reset", flag_ovr, 0);
    chk("R13", "unr after reset", flag_unr, 0);
    chk("R13", "go after reset", xfer_go, 0);
    begin
      automatic int seen = 0;
      for (int k = 0; k < 3; k++) begin
        push(DATA_W'(k));
        @(negedge clk);
        if (xfer_go) seen++;
      end
      chk("R13", "go without command", seen, 0);
    end

    // R6: configuration changed after capture
    do_reset();
    cmd(1'b0, 12'd64);
    cfg_fill_any = 1'b1; cfg_blk_len = 12'd4;
    begin
      automatic int first = 0;
      for (int k = 1; k <= 9; k++) begin
        push(DATA_W'(k));
        @(negedge clk);
        if (xfer_go && first == 0) first = k;
      end
      chk("R6", "go push index uses captured length", first, 8);
    end
    // R5: re-arm with FIFO already above threshold
    cmd(1'b0, 12'd4);
    chk("R5", "go one cycle after cmd", xfer_go, 0);
    @(negedge clk);
    chk("R5", "go two cycles after cmd", xfer_go, 1);
    @(negedge clk);
    chk("R5", "go single cycle", xfer_go, 0);

    // R7, R9, R12, R8: overfill, sticky in mode 0, ordered drain, underflow
    do_reset();
    for (int k = 1; k <= 17; k++) push(DATA_W'(100 + k));
    chk("R7", "level after overfill", level, 16);
    chk("R7", "ovr after overfill", flag_ovr, 1);
    rd_status();
    chk("R9", "ovr survives status read", flag_ovr, 1);
    cmd(1'b1, 12'd64);
    chk("R9", "ovr cleared by command", flag_ovr, 0);
    @(negedge clk);
    begin
      automatic int bad = 0;
      for (int k = 1; k <= 16; k++) begin
        pop();
        if (card_data != DATA_W'(100 + k)) bad++;
      end
      chk("R12", "words out of order", bad, 0);
      chk("R7", "last word is 16th push", card_data, 116);
    end
    chk("R12", "level after drain", level, 0);
    chk("R8", "unr before extra pop", flag_unr, 0);
    pop();
    chk("R8", "unr after pop on empty", flag_unr, 1);

    // R8: pop before release ignored
    do_reset();
    push(32'd7);
    pop();
    chk("R8", "level after early pop", level, 1);
    chk("R8", "unr after early pop", flag_unr, 0);

    // R10, R11: clear on status read
    cfg_clr_on_read = 1'b1;
    do_reset();
    for (int k = 1; k <= 17; k++) push(DATA_W'(k));
    chk("R10", "ovr set", flag_ovr, 1);
    cmd(1'b1, 12'd64);
    chk("R10", "ovr survives command", flag_ovr, 1);
    rd_status();
    chk("R10", "ovr cleared by status read", flag_ovr, 0);
    @(negedge clk);
    sys_push = 1'b1; stat_rd = 1'b1;
    @(negedge clk);
    sys_push = 1'b0; stat_rd = 1'b0;
    chk("R11", "ovr with event and clear together", flag_ovr, 1);
    rd_status();
    chk("R11", "ovr cleared afterwards", flag_ovr, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule